// File: doc/BRIEF.md
# Synthetic Traffic Destination Generator

This block picks where the next synthetic test packet goes in a square two-dimensional mesh. Each request names the source node, the size of the mesh as a bit count, and one of eight traffic patterns. Seven patterns are fixed permutations computed from the source ID and its coordinates. The eighth draws a uniformly distributed node from an internal pseudo-random register. A forced destination, when enabled, replaces whatever the pattern would have produced.

The result comes out registered one cycle after a generate strobe, together with a valid flag. The destination ID is also returned inside a request address, placed just above the cache-block offset bits, so a traffic injector can issue the request unchanged. The node count N is 2 to the power `node_lg2_i`. That exponent must be even and at least 2, so the mesh radix is 2^(`node_lg2_i`/2). The source X coordinate is the ID modulo the radix, and the Y coordinate is the ID divided by the radix.

Top module: `traffic_dest_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `dst_valid_o`, `dst_id_o` and `req_addr_o` are all zero.
- R2: A result is registered on the rising edge at which `gen_i` is high, and `dst_valid_o` is high for exactly that following cycle. With `gen_i` low, `dst_valid_o` falls and `dst_id_o` keeps its last value.
- R3: Pattern 0 (complement): the result has X = radix-1-srcX and Y = radix-1-srcY, and the ID is Y*radix + X.
- R4: Pattern 1 (bit reversal): the low log2(N) bits of the source appear in reverse order.
- R5: Pattern 2 (rotation): an even source s goes to s/2, and an odd source goes to floor(s/2) + N/2.
- R6: Pattern 3 (neighbor): X becomes (srcX+1) mod radix and Y is unchanged.
- R7: Pattern 4 (shuffle): a source s < N/2 goes to 2s, and any other source goes to 2s-N+1.
- R8: Pattern 5 (tornado): X becomes (srcX + radix/2 - 1) mod radix and Y is unchanged.
- R9: Pattern 6 (transpose): X and Y are exchanged.
- R10: Pattern 7 (uniform): the result is the low log2(N) bits of a 16-bit Galois shift register. That register resets to 0xACE1. On every generate strobe it shifts right by one and, if the bit shifted out was 1, is XORed with 0xB400. The value used is the one held before the strobe's step, and the register never holds zero.
- R11: With `force_en_i` high at a strobe, the result is `force_dst_i` whatever the pattern.
- R12: `req_addr_o` always equals `dst_id_o` shifted left by OFFSET_BITS (default 6), with zeros in the low bits.
- R13: Source bits at or above bit log2(N) are ignored. A pattern result never exceeds N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| gen_i | input | 1 | Generate strobe: compute a destination this cycle |
| src_id_i | input | 8 | Source node ID |
| node_lg2_i | input | 4 | log2 of the node count; even, from 2 to 8 |
| pattern_i | input | 3 | Traffic pattern select (0..7 as in R3-R10) |
| force_en_i | input | 1 | Use the forced destination instead of the pattern |
| force_dst_i | input | 8 | Forced destination ID |
| dst_valid_o | output | 1 | Result valid, one cycle after `gen_i` |
| dst_id_o | output | 8 | Destination node ID |
| req_addr_o | output | 32 | Destination placed above the block-offset bits |

## Verification
Every result is due exactly one rising edge after the strobe that requests it. The valid flag, the ID and the address all change at that same edge, because each sits in one register fed by the strobe-cycle inputs. The bench drives inputs at the falling edge and computes the expectation for that strobe from its own coordinate arithmetic and its own shift-register model. It then waits one rising edge and compares at the next falling edge. Cycles without a strobe are compared too: they must show the flag low and the ID unchanged.

// File: rtl/tdg_pkg.sv
package tdg_pkg;

    localparam int ID_W = 8;
    localparam int LG_W = $clog2(ID_W + 1);

    typedef logic [ID_W-1:0] node_id_t;
    typedef logic [LG_W-1:0] node_lg_t;

    typedef enum logic [2:0] {
        PAT_COMPLEMENT = 3'd0,
        PAT_REVERSE    = 3'd1,
        PAT_ROTATE     = 3'd2,
        PAT_NEIGHBOR   = 3'd3,
        PAT_SHUFFLE    = 3'd4,
        PAT_TORNADO    = 3'd5,
        PAT_TRANSPOSE  = 3'd6,
        PAT_UNIFORM    = 3'd7
    } pattern_e;

    typedef struct packed {
        node_id_t x;
        node_id_t y;
    } coord_t;

    // Mask of the low 'bits' bits
    function automatic node_id_t low_mask(node_lg_t bits);
        logic [ID_W:0] wide;
        wide = ({{ID_W{1'b0}}, 1'b1} << bits) - {{ID_W{1'b0}}, 1'b1};
        return wide[ID_W-1:0];
    endfunction

    function automatic node_id_t reverse_all(node_id_t v);
        node_id_t r;
        for (int i = 0; i < ID_W; i++) begin
            r[i] = v[ID_W-1-i];
        end
        return r;
    endfunction

    function automatic node_id_t compose(coord_t c, node_lg_t half);
        return (c.y << half) | c.x;
    endfunction

endpackage

// File: rtl/tdg_lfsr.sv
module tdg_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (step_i) begin
            state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
        end
    end

    assign state_o = state_q;

    assert_lfsr_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    assert_lfsr_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(state_q));

endmodule

// File: rtl/tdg_pattern_calc.sv
module tdg_pattern_calc
    import tdg_pkg::*;
(
    input  pattern_e pattern_i,
    input  node_id_t src_i,
    input  node_lg_t lg_i,
    input  node_id_t rnd_i,
    output node_id_t dst_o
);
    localparam node_lg_t ID_W_L = node_lg_t'(ID_W);

    node_lg_t half;
    node_id_t nmask, rmask, top_bit, s, half_radix, rev;
    coord_t   c, o;

    always_comb begin
        half       = lg_i >> 1;
        nmask      = low_mask(lg_i);
        rmask      = low_mask(half);
        top_bit    = nmask ^ (nmask >> 1);
        s          = src_i & nmask;
        c.x        = s & rmask;
        c.y        = (s >> half) & rmask;
        half_radix = (half == '0) ? '0 : (node_id_t'(1) << (half - node_lg_t'(1)));
        rev        = reverse_all(s) >> (ID_W_L - lg_i);
        o          = c;
        dst_o      = '0;
        unique case (pattern_i)
            PAT_COMPLEMENT: begin
                o.x   = ~c.x & rmask;
                o.y   = ~c.y & rmask;
                dst_o = compose(o, half);
            end
            PAT_REVERSE: dst_o = rev & nmask;
            PAT_ROTATE: dst_o = (s >> 1) | (s[0] ? top_bit : '0);
            PAT_NEIGHBOR: begin
                o.x   = (c.x + node_id_t'(1)) & rmask;
                dst_o = compose(o, half);
            end
            PAT_SHUFFLE: begin
                if ((s & top_bit) == '0) dst_o = (s << 1) & nmask;
                else                     dst_o = ((s << 1) - nmask) & nmask;
            end
            PAT_TORNADO: begin
                o.x   = (c.x + half_radix - node_id_t'(1)) & rmask;
                dst_o = compose(o, half);
            end
            PAT_TRANSPOSE: begin
                o.x   = c.y;
                o.y   = c.x;
                dst_o = compose(o, half);
            end
            PAT_UNIFORM: dst_o = rnd_i & nmask;
            default: dst_o = '0;
        endcase
    end

endmodule

// File: rtl/traffic_dest_gen.sv
module traffic_dest_gen
    import tdg_pkg::*;
#(
    parameter int              OFFSET_BITS = 6,
    parameter int              ADDR_W      = 32,
    parameter int              LFSR_W      = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gen_i,
    input  logic [ID_W-1:0]   src_id_i,
    input  logic [LG_W-1:0]   node_lg2_i,
    input  logic [2:0]        pattern_i,
    input  logic              force_en_i,
    input  logic [ID_W-1:0]   force_dst_i,
    output logic              dst_valid_o,
    output logic [ID_W-1:0]   dst_id_o,
    output logic [ADDR_W-1:0] req_addr_o
);
    localparam int RND_W = (LFSR_W < ID_W) ? LFSR_W : ID_W;

    logic [LFSR_W-1:0] lfsr_state;
    node_id_t          rnd, pat_dst, next_dst;
    logic              valid_q;
    node_id_t          dst_q;
    logic [ADDR_W-1:0] addr_q;

    tdg_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_TAPS),
        .SEED (LFSR_SEED)
    ) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .step_i  (gen_i),
        .state_o (lfsr_state)
    );

    always_comb begin
        rnd = '0;
        rnd[RND_W-1:0] = lfsr_state[RND_W-1:0];
    end

    tdg_pattern_calc u_calc (
        .pattern_i (pattern_e'(pattern_i)),
        .src_i     (src_id_i),
        .lg_i      (node_lg2_i),
        .rnd_i     (rnd),
        .dst_o     (pat_dst)
    );

    assign next_dst = force_en_i ? force_dst_i : pat_dst;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            dst_q   <= '0;
            addr_q  <= '0;
        end else begin
            valid_q <= gen_i;
            if (gen_i) begin
                dst_q  <= next_dst;
                addr_q <= ADDR_W'(next_dst) << OFFSET_BITS;
            end
        end
    end

    assign dst_valid_o = valid_q;
    assign dst_id_o    = dst_q;
    assign req_addr_o  = addr_q;

    assert_valid_after_gen_R2: assert property (@(posedge clk) disable iff (rst)
        gen_i |=> dst_valid_o);

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !gen_i |=> (!dst_valid_o && $stable(dst_id_o)));

    assert_force_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (gen_i && force_en_i) |=> (dst_id_o == $past(force_dst_i)));

    assert_dst_in_range_R13: assert property (@(posedge clk) disable iff (rst)
        (gen_i && !force_en_i) |=> ((dst_id_o >> $past(node_lg2_i)) == '0));

    assert_addr_matches_R12: assert property (@(posedge clk) disable iff (rst)
        req_addr_o == (ADDR_W'(dst_id_o) << OFFSET_BITS));

endmodule

// File: tb/traffic_dest_gen_tb.sv
`timescale 1ns/1ps
module traffic_dest_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gen = 1'b0;
    logic [7:0]  src = '0;
    logic [3:0]  lg  = 4'd4;
    logic [2:0]  pat = '0;
    logic        fen = 1'b0;
    logic [7:0]  fdst = '0;
    logic        valid;
    logic [7:0]  dst;
    logic [31:0] addr;

    int    checks = 0;
    int    errors = 0;
    int    lfsr_m = 'hACE1;
    bit    exp_valid = 1'b0;
    int    exp_dst = 0;
    string dst_tag = "R1";
    string pat_tag [7] = '{"R3", "R4", "R5", "R6", "R7", "R8", "R9"};

    always #2 clk = ~clk;

    traffic_dest_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .gen_i       (gen),
        .src_id_i    (src),
        .node_lg2_i  (lg),
        .pattern_i   (pat),
        .force_en_i  (fen),
        .force_dst_i (fdst),
        .dst_valid_o (valid),
        .dst_id_o    (dst),
        .req_addr_o  (addr)
    );

    task automatic check(string tag, string what, longint act, longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: %s got %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic int ref_dst(int p, int s, int n);
        int nn = 1 << n;
        int r  = 1 << (n / 2);
        int sx = s % r;
        int sy = s / r;
        int rv = 0;
        case (p)
            0: return (r - 1 - sy) * r + (r - 1 - sx);
            1: begin
                for (int i = 0; i < n; i++)
                    if ((s >> i) & 1) rv = rv | (1 << (n - 1 - i));
                return rv;
            end
            2: return (s % 2 == 0) ? s / 2 : s / 2 + nn / 2;
            3: return sy * r + (sx + 1) % r;
            4: return (s < nn / 2) ? 2 * s : 2 * s - nn + 1;
            5: return sy * r + (sx + r / 2 - 1) % r;
            default: return sx * r + sy;
        endcase
    endfunction

    // Drive at a falling edge, compare at the falling edge after the next rise
    task automatic cyc(bit g, int n, int p, int sraw, bit f, int fd);
        int nn = 1 << n;
        gen  = g;
        lg   = 4'(n);
        pat  = 3'(p);
        src  = 8'(sraw);
        fen  = f;
        fdst = 8'(fd);
        if (g) begin
            exp_valid = 1'b1;
            if (f) begin
                exp_dst = fd;
                dst_tag = "R11";
            end else if (p == 7) begin
                exp_dst = lfsr_m % nn;
                dst_tag = "R10";
            end else begin
                exp_dst = ref_dst(p, sraw % nn, n);
                dst_tag = (sraw >= nn) ? "R13" : pat_tag[p];
            end
            lfsr_m = (lfsr_m & 1) ? ((lfsr_m >> 1) ^ 'hB400) : (lfsr_m >> 1);
        end else begin
            exp_valid = 1'b0;
            dst_tag   = "R2";
        end
        @(posedge clk);
        @(negedge clk);
        check("R2", "valid", longint'(valid), longint'(exp_valid));
        check(dst_tag, "dst", longint'(dst), longint'(exp_dst));
        check("R12", "addr", longint'(addr), longint'(exp_dst) << 6);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "valid in reset", longint'(valid), 0);
        check("R1", "dst in reset", longint'(dst), 0);
        check("R1", "addr in reset", longint'(addr), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", "valid after reset", longint'(valid), 0);
        check("R1", "dst after reset", longint'(dst), 0);

        for (int n = 2; n <= 8; n += 2) begin
            for (int p = 0; p < 8; p++) begin
                for (int k = 0; k < 8; k++) begin
                    int nn = 1 << n;
                    int s  = (k * 37 + p * 11 + n * 5) % nn;
                    int sraw = s;
                    if (k == 4 && n < 8) sraw = (s + nn * (1 + p % 3)) % 256;
                    cyc(k != 3, n, p, sraw, k == 5, (k * 29 + p) % 256);
                end
            end
        end

        // exhaustive corners on the smallest and largest mesh
        for (int p = 0; p < 7; p++) begin
            for (int s = 0; s < 4; s++) cyc(1'b1, 2, p, s, 1'b0, 0);
            cyc(1'b1, 8, p, 0, 1'b0, 0);
            cyc(1'b1, 8, p, 255, 1'b0, 0);
        end
        for (int k = 0; k < 40; k++) cyc(1'b1, 8, 7, k, 1'b0, 0);
        cyc(1'b1, 4, 7, 3, 1'b1, 200);
        cyc(1'b0, 4, 0, 0, 1'b0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: run got 1 expected 0 timeouts");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule